// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the flag and enable state for six interrupt sources of a small CPU. The sources are two external lines, two timer overflows, the serial port and a supply power-fail warning. It turns that state into a 6-bit pending-request vector, one bit per source. Timers, the UART, the supply comparator and the CPU core sit outside. They feed the block with event pulses, a level from the comparator, conditioned external flags and one acknowledge strobe per source when the CPU vectors.

Each source has its own rule for clearing its flag. A timer flag clears when the CPU vectors to that timer. A serial flag clears only when software writes it. The power-fail flag clears when software reads it, but sets again while the supply stays low. Software reaches every bit through a bit-addressed port: a register select, a bit index, a write strobe with one data bit, and a read strobe. The selected bit always appears combinationally on the read-data output.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every flag and enable bit is 0, `pend_o` is 0 and `sw_rd_o` is 0.
- R2: Register select 0 is the enable register: bit 0 is external 0, bit 1 is timer 0, bit 2 is external 1, bit 3 is timer 1, bit 4 is serial, and bit 7 is the global enable. Select 1 holds the timer 0 flag at bit 5 and the timer 1 flag at bit 7. Select 2 holds the serial receive flag at bit 0 and the transmit flag at bit 1. Select 3 holds the power-fail enable at bit 3 and the power-fail flag at bit 5. A write changes only the addressed bit. All other positions read 0 and ignore writes.
- R3: A timer overflow pulse sets that timer's flag on the next clock. An `ack_i` strobe for that timer (bit 2 for timer 0, bit 4 for timer 1) clears it.
- R4: Serial receive-done and transmit-done pulses set their flags whether or not the serial enable is set. An acknowledge does not clear these flags; only a software write of 0 does.
- R5: The serial request is the OR of the receive and transmit flags.
- R6: The power-fail flag is set in every cycle in which `pwr_low_i` is 1, whatever its enable. Software writes to it are ignored.
- R7: A software read of the power-fail flag clears it after that cycle, unless `pwr_low_i` is 1, in which case it stays set.
- R8: `pend_o` order is bit 0 power-fail, bit 1 external 0, bit 2 timer 0, bit 3 external 1, bit 4 timer 1, bit 5 serial. Each bit is its flag AND its enable. Bits 1 to 5 also require the global enable; bit 0 does not.
- R9: The external requests follow `ext_flag_i` combinationally (bit 0 external 0, bit 1 external 1), masked as in R8.
- R10: When a hardware set meets a software clear or an acknowledge on the same flag in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_flag_i | input | 2 | Conditioned external interrupt flags |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_rx_done_i | input | 1 | Serial word received pulse |
| ser_tx_done_i | input | 1 | Serial word transmitted pulse |
| pwr_low_i | input | 1 | Supply below warning threshold |
| ack_i | input | 6 | CPU vectoring acknowledge, pend_o order |
| sw_sel_i | input | 2 | Software register select |
| sw_bit_i | input | 3 | Software bit index |
| sw_we_i | input | 1 | Software bit write strobe |
| sw_wd_i | input | 1 | Software write data bit |
| sw_re_i | input | 1 | Software read strobe |
| sw_rd_o | output | 1 | Selected bit value |
| pend_o | output | 6 | Pending request vector |

## Verification
The bench puts the three clear policies in conflict. It acknowledges a serial source that still has a flag up, which a design that shared the timer's clear-on-vector rule would drop. It reads the power-fail flag while the supply is still low, where a design that let the read win would report no pending warning. It raises overflow and receive pulses in the same cycle as a clearing write or an acknowledge, which exposes a wrong priority as a lost event. It also holds the global enable at 0 with the power-fail source active, which catches a design that gates that request. Writes to unimplemented positions and to the read-only flag are checked, since a wrong decode would let them store a bit.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_W    = $clog2(REG_W);
  localparam int NUM_REGS = 4;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int NUM_SRC  = 6;
  localparam int NUM_TMR  = 2;
  localparam int NUM_EXT  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_ENA  = 2'd0,
    SEL_TCTL = 2'd1,
    SEL_SCTL = 2'd2,
    SEL_PCTL = 2'd3
  } reg_sel_e;

  // enable register positions
  localparam int ENA_SER_BIT = 4;
  localparam int ENA_GLB_BIT = 7;
  // flag / control positions
  localparam int TF_BASE_BIT = 5;  // timer n flag at 5 + 2n
  localparam int PF_EN_BIT   = 3;
  localparam int PF_FLAG_BIT = 5;

  // pend_o ordering
  localparam int SRC_PF   = 0;
  localparam int SRC_EXT0 = 1;
  localparam int SRC_TMR0 = 2;
  localparam int SRC_EXT1 = 3;
  localparam int SRC_TMR1 = 4;
  localparam int SRC_SER  = 5;

  function automatic logic bit_hit(input logic [SEL_W-1:0] sel_i,
                                   input logic [BIT_W-1:0] pos_i,
                                   input reg_sel_e sel,
                                   input int pos);
    return (sel_i == sel) && (pos_i == BIT_W'(pos));
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter bit SW_WR = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic sw_we_i,
  input  logic sw_d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= 1'b0;
    else if (set_i)             q_o <= 1'b1;
    else if (SW_WR && sw_we_i)  q_o <= sw_d_i;
    else if (hw_clr_i)          q_o <= 1'b0;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);

  // R3 R7
  hw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i && !set_i && !(SW_WR && sw_we_i)) |=> !q_o);

  if (!SW_WR) begin : g_ro
    // R6
    ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_we_i && !set_i && !hw_clr_i) |=> (q_o == $past(q_o)));
  end
endmodule

// File: rtl/irq_req_mask.sv
module irq_req_mask
  import irq_flag_pkg::*;
(
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] ena_i,
  input  logic               glb_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == SRC_PF) begin : g_ungated
      assign pend_o[i] = flag_i[i] & ena_i[i];
    end else begin : g_gated
      assign pend_o[i] = flag_i[i] & ena_i[i] & glb_i;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_flag_i,
  input  logic [NUM_TMR-1:0] tmr_ovf_i,
  input  logic               ser_rx_done_i,
  input  logic               ser_tx_done_i,
  input  logic               pwr_low_i,
  input  logic [NUM_SRC-1:0] ack_i,
  input  logic [SEL_W-1:0]   sw_sel_i,
  input  logic [BIT_W-1:0]   sw_bit_i,
  input  logic               sw_we_i,
  input  logic               sw_wd_i,
  input  logic               sw_re_i,
  output logic               sw_rd_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [ENA_SER_BIT:0] ena_q;
  logic                 glb_q;
  logic [NUM_TMR-1:0]   tf_q;
  logic [1:0]           ser_q;
  logic                 pf_q;
  logic                 pf_en_q;
  logic                 unused_ack;

  assign unused_ack = ^{ack_i[SRC_PF], ack_i[SRC_EXT0], ack_i[SRC_EXT1], ack_i[SRC_SER]};

  // plain software enables
  for (genvar i = 0; i <= ENA_SER_BIT; i++) begin : g_ena
    irq_flag_cell u_cell (
      .clk_i, .rst_ni,
      .set_i   (1'b0),
      .hw_clr_i(1'b0),
      .sw_we_i (sw_we_i && bit_hit(sw_sel_i, sw_bit_i, SEL_ENA, i)),
      .sw_d_i  (sw_wd_i),
      .q_o     (ena_q[i])
    );
  end

  irq_flag_cell u_glb (
    .clk_i, .rst_ni,
    .set_i   (1'b0),
    .hw_clr_i(1'b0),
    .sw_we_i (sw_we_i && bit_hit(sw_sel_i, sw_bit_i, SEL_ENA, ENA_GLB_BIT)),
    .sw_d_i  (sw_wd_i),
    .q_o     (glb_q)
  );

  irq_flag_cell u_pf_en (
    .clk_i, .rst_ni,
    .set_i   (1'b0),
    .hw_clr_i(1'b0),
    .sw_we_i (sw_we_i && bit_hit(sw_sel_i, sw_bit_i, SEL_PCTL, PF_EN_BIT)),
    .sw_d_i  (sw_wd_i),
    .q_o     (pf_en_q)
  );

  // timer flags: cleared on vectoring
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    irq_flag_cell u_cell (
      .clk_i, .rst_ni,
      .set_i   (tmr_ovf_i[t]),
      .hw_clr_i(ack_i[SRC_TMR0 + 2*t]),
      .sw_we_i (sw_we_i && bit_hit(sw_sel_i, sw_bit_i, SEL_TCTL, TF_BASE_BIT + 2*t)),
      .sw_d_i  (sw_wd_i),
      .q_o     (tf_q[t])
    );
  end

  // serial flags: software clear only
  logic [1:0] ser_set;
  assign ser_set = {ser_tx_done_i, ser_rx_done_i};

  for (genvar s = 0; s < 2; s++) begin : g_ser
    irq_flag_cell u_cell (
      .clk_i, .rst_ni,
      .set_i   (ser_set[s]),
      .hw_clr_i(1'b0),
      .sw_we_i (sw_we_i && bit_hit(sw_sel_i, sw_bit_i, SEL_SCTL, s)),
      .sw_d_i  (sw_wd_i),
      .q_o     (ser_q[s])
    );
  end

  // power-fail flag: read-only, clear on read, level set
  logic pf_rd;
  assign pf_rd = sw_re_i && bit_hit(sw_sel_i, sw_bit_i, SEL_PCTL, PF_FLAG_BIT);

  irq_flag_cell #(.SW_WR(1'b0)) u_pf (
    .clk_i, .rst_ni,
    .set_i   (pwr_low_i),
    .hw_clr_i(pf_rd),
    .sw_we_i (sw_we_i && bit_hit(sw_sel_i, sw_bit_i, SEL_PCTL, PF_FLAG_BIT)),
    .sw_d_i  (sw_wd_i),
    .q_o     (pf_q)
  );

  // software read images
  logic [REG_W-1:0] img [NUM_REGS];
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) img[r] = '0;
    img[SEL_ENA][ENA_SER_BIT:0]   = ena_q;
    img[SEL_ENA][ENA_GLB_BIT]     = glb_q;
    for (int t = 0; t < NUM_TMR; t++) img[SEL_TCTL][TF_BASE_BIT + 2*t] = tf_q[t];
    img[SEL_SCTL][1:0]            = ser_q;
    img[SEL_PCTL][PF_EN_BIT]      = pf_en_q;
    img[SEL_PCTL][PF_FLAG_BIT]    = pf_q;
  end
  assign sw_rd_o = img[sw_sel_i][sw_bit_i];

  // source vectors in pend_o order
  logic [NUM_SRC-1:0] src_flag, src_ena;
  always_comb begin
    src_flag = '0;
    src_ena  = '0;
    src_flag[SRC_PF]   = pf_q;       src_ena[SRC_PF]   = pf_en_q;
    src_flag[SRC_EXT0] = ext_flag_i[0]; src_ena[SRC_EXT0] = ena_q[0];
    src_flag[SRC_TMR0] = tf_q[0];    src_ena[SRC_TMR0] = ena_q[1];
    src_flag[SRC_EXT1] = ext_flag_i[1]; src_ena[SRC_EXT1] = ena_q[2];
    src_flag[SRC_TMR1] = tf_q[1];    src_ena[SRC_TMR1] = ena_q[3];
    src_flag[SRC_SER]  = |ser_q;     src_ena[SRC_SER]  = ena_q[ENA_SER_BIT];
  end

  irq_req_mask u_mask (
    .flag_i(src_flag),
    .ena_i (src_ena),
    .glb_i (glb_q),
    .pend_o(pend_o)
  );

  // R8
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_q |-> (pend_o[NUM_SRC-1:1] == '0));

  // R4
  ser_ack_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[SRC_SER] && ser_q[0] && !(sw_we_i && sw_sel_i == SEL_SCTL)) |=> ser_q[0]);

  // R7
  pf_low_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_low_i && pf_rd) |=> pf_q);

  // R5
  ser_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_q && ena_q[ENA_SER_BIT] && (ser_q != 2'b00)) |-> pend_o[SRC_SER]);
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_flag = '0;
  logic [1:0] tmr_ovf = '0;
  logic       rx_done = 1'b0, tx_done = 1'b0, pwr_low = 1'b0;
  logic [5:0] ack = '0;
  logic [1:0] sel = '0;
  logic [2:0] bidx = '0;
  logic       we = 1'b0, wd = 1'b0, re = 1'b0;
  logic       rd;
  logic [5:0] pend;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_flag_i(ext_flag), .tmr_ovf_i(tmr_ovf),
    .ser_rx_done_i(rx_done), .ser_tx_done_i(tx_done), .pwr_low_i(pwr_low),
    .ack_i(ack), .sw_sel_i(sel), .sw_bit_i(bidx), .sw_we_i(we), .sw_wd_i(wd),
    .sw_re_i(re), .sw_rd_o(rd), .pend_o(pend)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sw_wr(logic [1:0] s, logic [2:0] b, logic v);
    sel = s; bidx = b; wd = v; we = 1'b1;
    cyc();
    we = 1'b0;
  endtask

  // reads the bit, checks it, and issues the read strobe for one cycle
  task automatic sw_rd_chk(string req, logic [1:0] s, logic [2:0] b, logic exp);
    sel = s; bidx = b; #1;
    check(req, {7'd0, rd}, {7'd0, exp});
    re = 1'b1;
    cyc();
    re = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pend", {2'b0, pend}, 8'h00);
    for (int b = 0; b < 8; b++) begin
      sel = 2'd0; bidx = 3'(b); #1;
      check("R1 enable bit", {7'd0, rd}, 8'h00);
    end
  endtask

  task automatic t_regmap();
    sw_wr(2'd0, 3'd2, 1'b1);
    sw_rd_chk("R2 ena bit2", 2'd0, 3'd2, 1'b1);
    sw_rd_chk("R2 ena bit0 untouched", 2'd0, 3'd0, 1'b0);
    sw_wr(2'd0, 3'd5, 1'b1);
    sw_rd_chk("R2 unimpl ena bit5", 2'd0, 3'd5, 1'b0);
    sw_wr(2'd2, 3'd1, 1'b1);
    sw_rd_chk("R2 tx flag write", 2'd2, 3'd1, 1'b1);
    sw_wr(2'd2, 3'd1, 1'b0);
    sw_wr(2'd0, 3'd2, 1'b0);
    sw_rd_chk("R2 ena bit2 clear", 2'd0, 3'd2, 1'b0);
  endtask

  task automatic t_timer();
    sw_wr(2'd0, 3'd1, 1'b1);
    sw_wr(2'd0, 3'd7, 1'b1);
    tmr_ovf[0] = 1'b1; cyc(); tmr_ovf[0] = 1'b0;
    check("R3 timer0 pend", {2'b0, pend}, 8'h04);
    sw_rd_chk("R3 timer0 flag bit5", 2'd1, 3'd5, 1'b1);
    ack[2] = 1'b1; cyc(); ack[2] = 1'b0;
    check("R3 timer0 ack clears", {2'b0, pend}, 8'h00);
    sw_rd_chk("R3 timer0 flag cleared", 2'd1, 3'd5, 1'b0);
    sw_wr(2'd0, 3'd1, 1'b0);
  endtask

  task automatic t_serial();
    rx_done = 1'b1; cyc(); rx_done = 1'b0;
    sw_rd_chk("R4 rx flag set while disabled", 2'd2, 3'd0, 1'b1);
    check("R4 no pend while disabled", {2'b0, pend}, 8'h00);
    sw_wr(2'd0, 3'd4, 1'b1);
    check("R5 serial pend rx", {2'b0, pend}, 8'h20);
    ack[5] = 1'b1; cyc(); ack[5] = 1'b0;
    check("R4 ack keeps serial", {2'b0, pend}, 8'h20);
    tx_done = 1'b1; cyc(); tx_done = 1'b0;
    sw_wr(2'd2, 3'd0, 1'b0);
    check("R5 serial pend tx only", {2'b0, pend}, 8'h20);
    sw_wr(2'd2, 3'd1, 1'b0);
    check("R4 software clear", {2'b0, pend}, 8'h00);
  endtask

  task automatic t_pwr();
    sw_wr(2'd0, 3'd7, 1'b0);
    sw_wr(2'd3, 3'd3, 1'b1);
    pwr_low = 1'b1; cyc(); pwr_low = 1'b0;
    check("R8 pf ungated by global", {2'b0, pend}, 8'h01);
    sw_wr(2'd3, 3'd5, 1'b0);
    check("R6 pf write ignored", {2'b0, pend}, 8'h01);
    sw_rd_chk("R7 pf read value", 2'd3, 3'd5, 1'b1);
    check("R7 read clears", {2'b0, pend}, 8'h00);
    pwr_low = 1'b1; cyc();
    sw_rd_chk("R7 read while low", 2'd3, 3'd5, 1'b1);
    check("R7 stays set while low", {2'b0, pend}, 8'h01);
    pwr_low = 1'b0;
    sw_rd_chk("R7 final read", 2'd3, 3'd5, 1'b1);
    sw_wr(2'd3, 3'd3, 1'b0);
    pwr_low = 1'b1; cyc(); pwr_low = 1'b0;
    sw_rd_chk("R6 set with enable off", 2'd3, 3'd5, 1'b1);
    check("R8 pf masked by enable", {2'b0, pend}, 8'h00);
  endtask

  task automatic t_ext();
    ext_flag = 2'b11;
    sw_wr(2'd0, 3'd0, 1'b1);
    sw_wr(2'd0, 3'd2, 1'b1);
    check("R9 ext gated by global", {2'b0, pend}, 8'h00);
    sw_wr(2'd0, 3'd7, 1'b1);
    check("R9 ext both", {2'b0, pend}, 8'h0A);
    ext_flag = 2'b10; #1;
    check("R9 ext1 only", {2'b0, pend}, 8'h08);
    ext_flag = 2'b00;
    sw_wr(2'd0, 3'd0, 1'b0);
    sw_wr(2'd0, 3'd2, 1'b0);
  endtask

  task automatic t_prec();
    sw_wr(2'd0, 3'd3, 1'b1);
    tmr_ovf[1] = 1'b1; ack[4] = 1'b1;
    sel = 2'd1; bidx = 3'd7; wd = 1'b0; we = 1'b1;
    cyc();
    tmr_ovf[1] = 1'b0; ack[4] = 1'b0; we = 1'b0;
    check("R10 timer1 set beats clear", {2'b0, pend}, 8'h10);
    ack[4] = 1'b1; cyc(); ack[4] = 1'b0;
    rx_done = 1'b1; sel = 2'd2; bidx = 3'd0; wd = 1'b0; we = 1'b1;
    cyc();
    rx_done = 1'b0; we = 1'b0;
    sw_rd_chk("R10 rx set beats clear", 2'd2, 3'd0, 1'b1);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #20 rst_n = 1'b1;
    cyc();
    t_reset();
    t_regmap();
    t_timer();
    t_serial();
    t_pwr();
    t_ext();
    t_prec();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule